// File: doc/BRIEF.md
# UART Receive Threshold and Line-Event Interrupt Controller

This block is the control path that sits beside the receive and transmit FIFOs of a UART. It passes transmit FIFO writes through only while the transmitter is enabled, and flags every write it refuses. It compares the receive FIFO fill count with one of four selectable trigger points and raises a maskable receive-ready interrupt. It also watches the RTS pin for changes.

The receiver is armed only after a full idle-high-then-falling sequence on RXD. A line that is already low when the receiver is switched on therefore can never be taken for a break or a start bit. Serialisation, baud timing, infrared coding and FIFO storage sit outside this block. It only consumes the FIFO fill count and produces the push strobe.

Top module: `uart_rx_irq_ctrl`

## Requirements
- R1: After reset, every output is low: `tx_push`, `tx_wr_err`, `rx_armed`, `rx_irq`, `rts_irq` and `rts_level`.
- R2: While `tx_en` is 1, `tx_push` equals `tx_wr_req` in the same cycle, and `tx_wr_err` stays 0.
- R3: While `tx_en` is 0, a write request gives `tx_push` = 0. `tx_wr_err` is then 1 for exactly the one cycle after the clock edge that samples the request.
- R4: `rx_trig_sel` selects the trigger point: 0 → 1 character, 1 → 4, 2 → 8, 3 → 14. `rx_level` is registered once. While `rx_ready_ie` is 1, `rx_irq` is 1 exactly when the registered level is at least the selected trigger point.
- R5: While `rx_ready_ie` is 0, `rx_irq` is 0 for every level, including a full FIFO (16).
- R6: `rx_irq` is level-sensitive. It falls one clock after `rx_level` drops below the trigger point, with no latching.
- R7: If RXD is low when `rx_en` is set, `rx_armed` stays 0 for as long as RXD stays low, and it is not set by RXD merely going high.
- R8: Once RXD has been seen high while the receiver is enabled, a falling edge on RXD sets `rx_armed` on the third clock edge after the fall. The edge path is a two-flop synchroniser followed by the state register. `rx_armed` then stays 1 while `rx_en` stays 1.
- R9: Clearing `rx_en` clears `rx_armed` at the next clock edge. Re-enabling requires a new high-then-falling sequence before `rx_armed` returns to 1.
- R10: `rts_level` follows the RTS pin after a two-flop synchroniser, two clock edges after the pin changes.
- R11: When `rts_chg_ie` is 1, a change of the synchronised RTS level sets `rts_irq` three clock edges after the pin change. `rts_irq` stays 1 until it is cleared.
- R12: A change of RTS while `rts_chg_ie` is 0 does not set `rts_irq`, and it is not reported later when the enable is set.
- R13: A one-cycle `rts_chg_clr` pulse clears `rts_irq` at the next edge. If a new change is detected in that same cycle, the new change wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| rx_ready_ie | input | 1 | Receive-ready interrupt enable |
| rx_trig_sel | input | 2 | Receive trigger point code |
| rts_chg_ie | input | 1 | RTS change interrupt enable |
| rxd | input | 1 | Serial receive line, idle high |
| rts_pin | input | 1 | Asynchronous RTS pin |
| rx_level | input | 5 | Receive FIFO fill count, 0 to 16 |
| tx_wr_req | input | 1 | Transmit FIFO write request |
| rts_chg_clr | input | 1 | Write-one-to-clear strobe for the RTS change flag |
| tx_push | output | 1 | Accepted transmit FIFO push |
| tx_wr_err | output | 1 | One-cycle pulse for a refused write |
| rx_armed | output | 1 | Receiver ready to accept a start bit |
| rx_irq | output | 1 | Receive-ready interrupt |
| rts_level | output | 1 | Synchronised RTS level |
| rts_irq | output | 1 | Sticky RTS change interrupt |

## Verification
A wrong arming state shows on `rx_armed` within three clocks of an RXD edge. The bench checks every cycle around each edge, so an early arm, a late arm or an arm from an already-low line shows up as a single-cycle mismatch. A wrong trigger decode or a wrong comparison shows on `rx_irq` one clock after a level is applied. This is checked across all seventeen levels for every code, so an off-by-one at any boundary is caught. A broken RTS synchroniser, a broken sticky flag or a broken clear shows on `rts_level` or `rts_irq` at an exact edge count after the pin toggles or the strobe pulses.

// File: rtl/uart_rx_irq_ctrl.sv
module uart_rx_irq_ctrl #(
  parameter int LVL_W  = 5,
  parameter int TRIG_A = 1,
  parameter int TRIG_B = 4,
  parameter int TRIG_C = 8,
  parameter int TRIG_D = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             rx_en,
  input  logic             rx_ready_ie,
  input  logic [1:0]       rx_trig_sel,
  input  logic             rts_chg_ie,
  input  logic             rxd,
  input  logic             rts_pin,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             tx_wr_req,
  input  logic             rts_chg_clr,
  output logic             tx_push,
  output logic             tx_wr_err,
  output logic             rx_armed,
  output logic             rx_irq,
  output logic             rts_level,
  output logic             rts_irq
);

  typedef enum logic [1:0] {S_OFF, S_WHIGH, S_WFALL, S_ARMED} arm_t;

  arm_t             st_q, st_d;
  logic [1:0]       rxd_sync, rts_sync;
  logic             rts_d, rts_edge, err_q, flag_q;
  logic [LVL_W-1:0] lvl_q, trig;
  logic             rxd_s;

  assign rxd_s     = rxd_sync[1];
  assign rts_level = rts_sync[1];
  assign rts_edge  = rts_level ^ rts_d;

  // transmit write gating
  assign tx_push   = tx_wr_req & tx_en;
  assign tx_wr_err = err_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= tx_wr_req & ~tx_en;

  // receive trigger compare
  always_comb
    case (rx_trig_sel)
      2'd0:    trig = LVL_W'(TRIG_A);
      2'd1:    trig = LVL_W'(TRIG_B);
      2'd2:    trig = LVL_W'(TRIG_C);
      default: trig = LVL_W'(TRIG_D);
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= rx_level;

  assign rx_irq = rx_ready_ie & (lvl_q >= trig);

  // receiver arming
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rxd_sync <= 2'b11;
    else        rxd_sync <= {rxd_sync[0], rxd};

  always_comb begin
    st_d = st_q;
    if (!rx_en) st_d = S_OFF;
    else
      case (st_q)
        S_OFF:   st_d = S_WHIGH;
        S_WHIGH: if (rxd_s)  st_d = S_WFALL;
        S_WFALL: if (!rxd_s) st_d = S_ARMED;
        default: st_d = S_ARMED;
      endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st_q <= S_OFF;
    else        st_q <= st_d;

  assign rx_armed = (st_q == S_ARMED);

  // RTS change detection
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rts_sync <= 2'b00;
      rts_d    <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      rts_sync <= {rts_sync[0], rts_pin};
      rts_d    <= rts_level;
      if (rts_edge && rts_chg_ie) flag_q <= 1'b1;
      else if (rts_chg_clr)       flag_q <= 1'b0;
    end

  assign rts_irq = flag_q;

  assert_err_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr_err |-> $past(tx_wr_req && !tx_en));
  assert_irq_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rx_ready_ie && ($past(rx_level) != '0));
  assert_arm_after_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_armed) |-> $past(st_q == S_WFALL) && !$past(rxd_s));
  assert_disarm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !rx_armed);
  assert_flag_needs_ie_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rts_irq) |-> $past(rts_chg_ie));
  assert_clear_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_chg_clr && !rts_edge) |=> !rts_irq);

endmodule

// File: tb/uart_rx_irq_ctrl_tb.sv
module uart_rx_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SIG_PUSH = 0, SIG_ERR = 1, SIG_ARM = 2, SIG_RXIRQ = 3, SIG_RTSLVL = 4, SIG_RTSIRQ = 5;

  typedef struct {
    int    sel;
    logic  exp;
    string tag;
  } sb_item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_en = 0, rx_en = 0, rx_ready_ie = 0, rts_chg_ie = 0, rxd = 1, rts_pin = 0;
  logic tx_wr_req = 0, rts_chg_clr = 0;
  logic [1:0] rx_trig_sel = 0;
  logic [4:0] rx_level = 0;
  logic tx_push, tx_wr_err, rx_armed, rx_irq, rts_level, rts_irq;

  int checks = 0, fails = 0;
  bit done = 0;
  sb_item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en), .rx_ready_ie(rx_ready_ie),
    .rx_trig_sel(rx_trig_sel), .rts_chg_ie(rts_chg_ie), .rxd(rxd), .rts_pin(rts_pin),
    .rx_level(rx_level), .tx_wr_req(tx_wr_req), .rts_chg_clr(rts_chg_clr),
    .tx_push(tx_push), .tx_wr_err(tx_wr_err), .rx_armed(rx_armed), .rx_irq(rx_irq),
    .rts_level(rts_level), .rts_irq(rts_irq));

  function automatic logic pick(int sel);
    case (sel)
      SIG_PUSH:   return tx_push;
      SIG_ERR:    return tx_wr_err;
      SIG_ARM:    return rx_armed;
      SIG_RXIRQ:  return rx_irq;
      SIG_RTSLVL: return rts_level;
      default:    return rts_irq;
    endcase
  endfunction

  function automatic int trig_of(int code);
    case (code)
      0: return 1;
      1: return 4;
      2: return 8;
      default: return 14;
    endcase
  endfunction

  // driver side: expectation holds just after the next rising edge
  task automatic expect_sig(int sel, logic exp, string tag);
    sb_item_t it;
    it.sel = sel; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // monitor
  initial begin
    sb_item_t it;
    logic act;
    forever begin
      @(posedge clk);
      #1;
      while (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        act = pick(it.sel);
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s: signal %0d actual %0b expected %0b", it.tag, it.sel, act, it.exp);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    // R1 reset state
    expect_sig(SIG_PUSH, 0, "R1"); expect_sig(SIG_ERR, 0, "R1"); expect_sig(SIG_ARM, 0, "R1");
    expect_sig(SIG_RXIRQ, 0, "R1"); expect_sig(SIG_RTSLVL, 0, "R1"); expect_sig(SIG_RTSIRQ, 0, "R1");
    tick();

    // R2 accepted writes
    tx_en = 1; tx_wr_req = 1;
    expect_sig(SIG_PUSH, 1, "R2"); expect_sig(SIG_ERR, 0, "R2"); tick();
    tx_wr_req = 0;
    expect_sig(SIG_PUSH, 0, "R2"); expect_sig(SIG_ERR, 0, "R2"); tick();

    // R3 refused write
    tx_en = 0; tx_wr_req = 1;
    expect_sig(SIG_PUSH, 0, "R3"); expect_sig(SIG_ERR, 1, "R3"); tick();
    tx_wr_req = 0;
    expect_sig(SIG_ERR, 0, "R3"); tick();

    // R4 trigger sweep, rising levels
    rx_ready_ie = 1;
    for (int code = 0; code < 4; code++) begin
      rx_trig_sel = 2'(code);
      for (int lvl = 0; lvl <= 16; lvl++) begin
        rx_level = 5'(lvl);
        expect_sig(SIG_RXIRQ, lvl >= trig_of(code), "R4"); tick();
      end
    end
    // R6 falling levels release the interrupt
    rx_trig_sel = 2'd2;
    for (int lvl = 16; lvl >= 0; lvl--) begin
      rx_level = 5'(lvl);
      expect_sig(SIG_RXIRQ, lvl >= 8, "R6"); tick();
    end

    // R5 masked
    rx_ready_ie = 0; rx_level = 5'd16; rx_trig_sel = 2'd0;
    expect_sig(SIG_RXIRQ, 0, "R5"); tick();
    expect_sig(SIG_RXIRQ, 0, "R5"); tick();
    rx_level = 0;

    // R7 enable with line already low
    rxd = 0; repeat (4) tick();
    rx_en = 1;
    repeat (6) begin expect_sig(SIG_ARM, 0, "R7"); tick(); end
    rxd = 1;
    repeat (4) begin expect_sig(SIG_ARM, 0, "R7"); tick(); end
    // R8 falling edge arms on third edge
    rxd = 0;
    expect_sig(SIG_ARM, 0, "R8"); tick();
    expect_sig(SIG_ARM, 0, "R8"); tick();
    expect_sig(SIG_ARM, 1, "R8"); tick();
    rxd = 1;
    expect_sig(SIG_ARM, 1, "R8"); tick();
    expect_sig(SIG_ARM, 1, "R8"); tick();

    // R9 disable drops, re-enable needs a new fall
    rx_en = 0;
    expect_sig(SIG_ARM, 0, "R9"); tick();
    rx_en = 1;
    repeat (4) begin expect_sig(SIG_ARM, 0, "R9"); tick(); end
    rxd = 0;
    expect_sig(SIG_ARM, 0, "R9"); tick();
    expect_sig(SIG_ARM, 0, "R9"); tick();
    expect_sig(SIG_ARM, 1, "R9"); tick();

    // R10 / R11 RTS rise with interrupt enabled
    rts_chg_ie = 1; rts_pin = 1;
    expect_sig(SIG_RTSLVL, 0, "R10"); expect_sig(SIG_RTSIRQ, 0, "R11"); tick();
    expect_sig(SIG_RTSLVL, 1, "R10"); expect_sig(SIG_RTSIRQ, 0, "R11"); tick();
    expect_sig(SIG_RTSIRQ, 1, "R11"); tick();
    repeat (3) begin expect_sig(SIG_RTSIRQ, 1, "R11"); tick(); end

    // R13 clear strobe
    rts_chg_clr = 1;
    expect_sig(SIG_RTSIRQ, 0, "R13"); tick();
    rts_chg_clr = 0;
    expect_sig(SIG_RTSIRQ, 0, "R13"); tick();

    // R12 change while masked
    rts_chg_ie = 0; rts_pin = 0;
    expect_sig(SIG_RTSLVL, 1, "R10"); expect_sig(SIG_RTSIRQ, 0, "R12"); tick();
    expect_sig(SIG_RTSLVL, 0, "R10"); expect_sig(SIG_RTSIRQ, 0, "R12"); tick();
    expect_sig(SIG_RTSIRQ, 0, "R12"); tick();
    rts_chg_ie = 1;
    repeat (3) begin expect_sig(SIG_RTSIRQ, 0, "R12"); tick(); end

    tick(); tick();
    done = 1;
    report();
  end
endmodule